// File: doc/BRIEF.md
# Direct-Sequence Spreading Transmitter with Clock Generation

This block sits on the transmit side of a spread-spectrum radio datapath. It runs from one master clock. From that clock it derives its timing strobes, produces a maximal-length pseudo-noise chip sequence, and spreads a slow scrambled data stream with that sequence. It also delivers phase-modulated copies of the chip streams for the analog stages downstream.

A data timing generator divides the master clock into single-cycle strobes at three points in the bit timing:
- the start of every chip;
- the start of every data bit, which marks the voice-codec rate;
- the last cycle of every data bit, which is the scrambler strobe that asks for the next bit.

A modulator clock generator produces two square waves from the same counters. The slow one has a period of exactly one chip. The fast one runs at twice the frequency of the slow one.

Each data bit spans a whole number of chips. The spread chip is the pseudo-noise chip XOR the current data bit. Both the spread chip and the bare pseudo-noise chip are bi-phase modulated: each is XORed with the slow modulator clock. All counters share one synchronous reset, so every phase relation is fixed after reset.

Top module: `dsss_tx_spreader`

## Requirements
- R1: While `rst` is high, after a clock edge every output is 0 except `scr_en`, which is 1.
- R2: Count state s from 0 at the first edge after reset is released, so that output values after edge t belong to s = t-1. With D = CHIP_DIV and phase ph = s mod D, `chip_en` is 1 exactly when ph = 0.
- R3: With chip index c = s div D and N = CHIPS_PER_BIT, `codec_en` is 1 exactly when ph = 0 and c mod N = 0. This is the first cycle of every data bit.
- R4: `scr_en` is 1 exactly when ph = D-1 and c mod N = N-1. The value of `data_in` at the clock edge that ends such a cycle (or at the first edge after reset) becomes the data bit for the next N chips.
- R5: `mod_clk_lo` is 1 when ph < D/2 and 0 otherwise, so its period is one chip. `mod_clk_hi` is 1 when (ph mod D/2) < D/4, so it runs at twice the frequency of `mod_clk_lo`.
- R6: `pn_chip` for chip c is bit 0 of a 15-bit register a. Register a holds PN_SEED for chip 0 and advances once per chip as a <= {a[0]^a[1], a[14:1]}. The resulting sequence repeats every 32767 chips.
- R7: `spread_chip` equals `pn_chip` XOR the current data bit. Their XOR is constant over the N chips of a bit.
- R8: `pn_bpsk` = `pn_chip` XOR `mod_clk_lo`, and `spread_bpsk` = `spread_chip` XOR `mod_clk_lo`, taken in the same cycle.
- R9: Raising `rst` in the middle of a run returns all phases, the chip sequence and the data timing to the state of R1. Releasing it again restarts at s = 0 with the PN_SEED chip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 1 | Scrambled data bit, taken at the edge that ends a `scr_en` cycle |
| chip_en | output | 1 | Strobe on the first master cycle of each chip |
| codec_en | output | 1 | Strobe on the first master cycle of each data bit |
| scr_en | output | 1 | Strobe on the last master cycle of each data bit |
| mod_clk_lo | output | 1 | Modulator clock, one period per chip |
| mod_clk_hi | output | 1 | Modulator clock at twice the frequency of `mod_clk_lo` |
| pn_chip | output | 1 | Pseudo-noise chip |
| spread_chip | output | 1 | PN chip XOR data bit |
| pn_bpsk | output | 1 | PN chip XOR `mod_clk_lo` |
| spread_bpsk | output | 1 | Spread chip XOR `mod_clk_lo` |

## Verification
The hardest condition to reach from the ports is the wrap of the 15-bit sequence after 32767 chips. A fault in the feedback taps or in the seed handling often shows up only as a wrong period. The bench therefore runs a reduced configuration (4 master cycles per chip, 4 chips per bit) for more than a full sequence period. It records every chip and compares the chips after the wrap with the first ones.

A second hard condition is a reset raised in the middle of a data bit, where stale phase or a stale data bit could leak into the next run. The bench forces this by raising `rst` part-way through a bit and then checking the restart cycle by cycle.

// File: rtl/dsss_pkg.sv
package dsss_pkg;

  localparam int PN_W = 15;

  // One step of the maximal-length shift register; bit 0 is the chip.
  function automatic logic [PN_W-1:0] pn_advance(input logic [PN_W-1:0] s);
    return {s[0] ^ s[1], s[PN_W-1:1]};
  endfunction

endpackage

// File: rtl/data_clk_gen.sv
module data_clk_gen #(
  parameter int CHIP_DIV      = 4,
  parameter int CHIPS_PER_BIT = 64
) (
  input  logic                            clk,
  input  logic                            rst,
  output logic [$clog2(CHIP_DIV)-1:0]     ph_next,
  output logic                            chip_start_n,
  output logic                            bit_start_n,
  output logic                            chip_en,
  output logic                            codec_en,
  output logic                            scr_en
);
  localparam int PW = $clog2(CHIP_DIV);
  localparam int CW = (CHIPS_PER_BIT > 1) ? $clog2(CHIPS_PER_BIT) : 1;
  localparam logic [PW-1:0] PH_LAST = PW'(CHIP_DIV - 1);
  localparam logic [CW-1:0] CI_LAST = CW'(CHIPS_PER_BIT - 1);

  logic [PW-1:0] ph;
  logic [CW-1:0] ci, ci_next;

  always_comb begin
    ph_next = (ph == PH_LAST) ? '0 : ph + 1'b1;
    ci_next = ci;
    if (ph == PH_LAST)
      ci_next = (ci == CI_LAST) ? '0 : ci + 1'b1;
  end

  assign chip_start_n = (ph_next == '0);
  assign bit_start_n  = chip_start_n && (ci_next == '0);

  // Reset parks the counters one cycle before state zero.
  always_ff @(posedge clk) begin
    if (rst) begin
      ph       <= PH_LAST;
      ci       <= CI_LAST;
      chip_en  <= 1'b0;
      codec_en <= 1'b0;
      scr_en   <= 1'b1;
    end else begin
      ph       <= ph_next;
      ci       <= ci_next;
      chip_en  <= chip_start_n;
      codec_en <= bit_start_n;
      scr_en   <= (ph_next == PH_LAST) && (ci_next == CI_LAST);
    end
  end
endmodule

// File: rtl/mod_clk_gen.sv
module mod_clk_gen #(
  parameter int CHIP_DIV = 4
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [$clog2(CHIP_DIV)-1:0] ph_next,
  output logic                        lo_next,
  output logic                        mod_clk_lo,
  output logic                        mod_clk_hi
);
  localparam int HALF = CHIP_DIV / 2;
  localparam int QTR  = CHIP_DIV / 4;

  logic hi_next;

  always_comb begin
    lo_next = (int'(ph_next) < HALF);
    hi_next = ((int'(ph_next) % HALF) < QTR);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mod_clk_lo <= 1'b0;
      mod_clk_hi <= 1'b0;
    end else begin
      mod_clk_lo <= lo_next;
      mod_clk_hi <= hi_next;
    end
  end
endmodule

// File: rtl/pn_gen.sv
module pn_gen
  import dsss_pkg::*;
#(
  parameter logic [PN_W-1:0] PN_SEED = '1
) (
  input  logic clk,
  input  logic rst,
  input  logic chip_start_n,
  output logic pn_next
);
  logic [PN_W-1:0] lfsr, lfsr_next;
  logic            started;

  // The first chip after reset uses the seed; later chips step.
  always_comb begin
    lfsr_next = lfsr;
    if (chip_start_n && started)
      lfsr_next = pn_advance(lfsr);
  end

  assign pn_next = lfsr_next[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      lfsr    <= PN_SEED;
      started <= 1'b0;
    end else begin
      lfsr <= lfsr_next;
      if (chip_start_n)
        started <= 1'b1;
    end
  end
endmodule

// File: rtl/dsss_tx_spreader.sv
module dsss_tx_spreader
  import dsss_pkg::*;
#(
  parameter int               CHIP_DIV      = 4,
  parameter int               CHIPS_PER_BIT = 64,
  parameter logic [PN_W-1:0]  PN_SEED       = '1
) (
  input  logic clk,
  input  logic rst,
  input  logic data_in,
  output logic chip_en,
  output logic codec_en,
  output logic scr_en,
  output logic mod_clk_lo,
  output logic mod_clk_hi,
  output logic pn_chip,
  output logic spread_chip,
  output logic pn_bpsk,
  output logic spread_bpsk
);
  localparam int PW = $clog2(CHIP_DIV);

  generate
    if ((CHIP_DIV < 4) || (CHIP_DIV % 4 != 0)) begin : g_bad_div
      $error("CHIP_DIV must be a multiple of 4");
    end
    if (CHIPS_PER_BIT < 2) begin : g_bad_n
      $error("CHIPS_PER_BIT must be at least 2");
    end
  endgenerate

  logic [PW-1:0] ph_next;
  logic          chip_start_n, bit_start_n;
  logic          lo_next, pn_next;
  logic          data_q, bit_next;

  data_clk_gen #(.CHIP_DIV(CHIP_DIV), .CHIPS_PER_BIT(CHIPS_PER_BIT)) u_dclk (
    .clk(clk), .rst(rst), .ph_next(ph_next),
    .chip_start_n(chip_start_n), .bit_start_n(bit_start_n),
    .chip_en(chip_en), .codec_en(codec_en), .scr_en(scr_en)
  );

  mod_clk_gen #(.CHIP_DIV(CHIP_DIV)) u_mclk (
    .clk(clk), .rst(rst), .ph_next(ph_next), .lo_next(lo_next),
    .mod_clk_lo(mod_clk_lo), .mod_clk_hi(mod_clk_hi)
  );

  pn_gen #(.PN_SEED(PN_SEED)) u_pn (
    .clk(clk), .rst(rst), .chip_start_n(chip_start_n), .pn_next(pn_next)
  );

  assign bit_next = bit_start_n ? data_in : data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      data_q      <= 1'b0;
      pn_chip     <= 1'b0;
      spread_chip <= 1'b0;
      pn_bpsk     <= 1'b0;
      spread_bpsk <= 1'b0;
    end else begin
      data_q      <= bit_next;
      pn_chip     <= pn_next;
      spread_chip <= pn_next ^ bit_next;
      pn_bpsk     <= pn_next ^ lo_next;
      spread_bpsk <= pn_next ^ bit_next ^ lo_next;
    end
  end
endmodule

// File: rtl/dsss_tx_spreader_chk.sv
module dsss_tx_spreader_chk (
  input logic clk,
  input logic rst,
  input logic data_in,
  input logic chip_en,
  input logic codec_en,
  input logic scr_en,
  input logic mod_clk_lo,
  input logic mod_clk_hi,
  input logic pn_chip,
  input logic spread_chip,
  input logic pn_bpsk,
  input logic spread_bpsk
);
  // R3
  codec_on_chip_chk: assert property (@(posedge clk) disable iff (rst)
    codec_en |-> chip_en);

  // R4
  scr_then_codec_chk: assert property (@(posedge clk) disable iff (rst)
    scr_en |=> codec_en);

  // R2
  chip_single_chk: assert property (@(posedge clk) disable iff (rst)
    chip_en |=> !chip_en);

  // R5
  lo_rise_on_chip_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mod_clk_lo) |-> (chip_en && mod_clk_hi));

  // R6
  pn_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !chip_en |=> (chip_en || $stable(pn_chip)));

  // R7
  bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !codec_en |-> ((spread_chip ^ pn_chip) == $past(spread_chip ^ pn_chip)));

  // R8
  bpsk_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (pn_bpsk ^ spread_bpsk) == (pn_chip ^ spread_chip));

  // R8
  pn_bpsk_chk: assert property (@(posedge clk) disable iff (rst)
    pn_bpsk == (pn_chip ^ mod_clk_lo));
endmodule

bind dsss_tx_spreader dsss_tx_spreader_chk u_chk (
  .clk(clk), .rst(rst), .data_in(data_in), .chip_en(chip_en),
  .codec_en(codec_en), .scr_en(scr_en), .mod_clk_lo(mod_clk_lo),
  .mod_clk_hi(mod_clk_hi), .pn_chip(pn_chip), .spread_chip(spread_chip),
  .pn_bpsk(pn_bpsk), .spread_bpsk(spread_bpsk)
);

// File: tb/sim_dsss_tx_spreader.sv
`timescale 1ns/1ps
module sim_dsss_tx_spreader;
  localparam int D = 4;
  localparam int N = 4;
  localparam logic [14:0] SEED = 15'h7FFF;
  localparam int PERIOD = 32767;
  localparam int LONG_CHIPS = 33000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic data_in = 1'b0;
  logic chip_en, codec_en, scr_en, mod_clk_lo, mod_clk_hi;
  logic pn_chip, spread_chip, pn_bpsk, spread_bpsk;

  int total = 0;
  int bad = 0;
  int t;
  logic [14:0] mreg;
  logic cur_bit, next_bit;
  logic [31:0] rng = 32'h1234_5678;
  logic obs [0:LONG_CHIPS-1];

  always #2.5 clk = ~clk;

  dsss_tx_spreader #(.CHIP_DIV(D), .CHIPS_PER_BIT(N), .PN_SEED(SEED)) u0 (
    .clk(clk), .rst(rst), .data_in(data_in), .chip_en(chip_en),
    .codec_en(codec_en), .scr_en(scr_en), .mod_clk_lo(mod_clk_lo),
    .mod_clk_hi(mod_clk_hi), .pn_chip(pn_chip), .spread_chip(spread_chip),
    .pn_bpsk(pn_bpsk), .spread_bpsk(spread_bpsk)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic new_bit();
    rng = rng ^ (rng << 13);
    rng = rng ^ (rng >> 17);
    rng = rng ^ (rng << 5);
    next_bit = rng[7];
    data_in = next_bit;
  endtask

  // R1 / R9: reset values.
  task automatic check_reset(input string tag);
    chk(chip_en == 0, tag, chip_en, 0);
    chk(codec_en == 0, tag, codec_en, 0);
    chk(scr_en == 1, tag, scr_en, 1);
    chk(mod_clk_lo == 0 && mod_clk_hi == 0, tag, {mod_clk_lo, mod_clk_hi}, 0);
    chk(pn_chip == 0 && spread_chip == 0, tag, {pn_chip, spread_chip}, 0);
    chk(pn_bpsk == 0 && spread_bpsk == 0, tag, {pn_bpsk, spread_bpsk}, 0);
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    new_bit();
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    check_reset(tag);
    rst = 1'b0;
    t = 0;
    mreg = SEED;
  endtask

  task automatic run(input int cycles, input bit record);
    for (int k = 0; k < cycles; k++) begin
      int s, ph, c, ci;
      logic e_lo, e_hi, e_pn, e_sp;
      @(posedge clk);
      t++;
      @(negedge clk);
      s = t - 1;
      ph = s % D;
      c = s / D;
      ci = c % N;
      if (ph == 0 && s > 0) mreg = {mreg[0] ^ mreg[1], mreg[14:1]};
      if (ph == 0 && ci == 0) cur_bit = next_bit;
      e_lo = (ph < D / 2);
      e_hi = ((ph % (D / 2)) < D / 4);
      e_pn = mreg[0];
      e_sp = e_pn ^ cur_bit;
      chk(chip_en == (ph == 0), "R2 chip_en", chip_en, ph == 0);
      chk(codec_en == (ph == 0 && ci == 0), "R3 codec_en", codec_en, ph == 0 && ci == 0);
      chk(scr_en == (ph == D - 1 && ci == N - 1), "R4 scr_en", scr_en, ph == D - 1 && ci == N - 1);
      chk(mod_clk_lo == e_lo, "R5 mod_clk_lo", mod_clk_lo, e_lo);
      chk(mod_clk_hi == e_hi, "R5 mod_clk_hi", mod_clk_hi, e_hi);
      chk(pn_chip == e_pn, "R6 pn_chip", pn_chip, e_pn);
      chk(spread_chip == e_sp, "R7 spread_chip", spread_chip, e_sp);
      chk(pn_bpsk == (e_pn ^ e_lo), "R8 pn_bpsk", pn_bpsk, e_pn ^ e_lo);
      chk(spread_bpsk == (e_sp ^ e_lo), "R8 spread_bpsk", spread_bpsk, e_sp ^ e_lo);
      if (record && ph == 0 && c < LONG_CHIPS) obs[c] = pn_chip;
      if (ph == D - 1 && ci == N - 1) new_bit();
    end
  endtask

  initial begin
    #(200000 * 5);
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset("R1 reset");
    run(150, 1'b0);
    // R9: reset in the middle of a data bit, then a fresh run.
    run(5, 1'b0);
    do_reset("R9 mid-run reset");
    run(LONG_CHIPS * D, 1'b1);
    // R6: the sequence wraps after 32767 chips.
    for (int c = 0; c + PERIOD < LONG_CHIPS; c++)
      chk(obs[c + PERIOD] == obs[c], "R6 period", obs[c + PERIOD], obs[c]);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule